// File: doc/BRIEF.md
# Interlocked Handshake Read Link

This block carries single-word reads between a requesting master and a memory-side responder that run on unrelated clocks. The two parties share one set of data lines, which carry first the address and then the read word. Three control lines pace the exchange: a request from the master, a data-ready from the responder, and an acknowledge that each side raises in its own phase of the transfer. The acknowledge is a wired-OR of the two contributions.

No step depends on counting clock edges on the far side. Each side passes the partner's control lines through a two-flop synchronizer and moves on only after it sees the partner's level change. A local command port on the master side starts a read. The captured word comes back on the same side with a one-cycle done pulse. The responder holds a small array and waits a parameterised access delay, counted in its own clock cycles, before it offers the word.

Top module: `hsk_read_link`

## Requirements
- R1: After both resets, `cmd_ready` is 1, `rsp_done` is 0, and request, acknowledge and data-ready are all low.
- R2: A read of address `a` returns the word at cell `a`. After reset, cell `i` holds the low DW bits of `(i * 0x9E37) XOR 0x5AC3`.
- R3: The master raises the request and drives the address onto the data lines. It keeps both until it sees the acknowledge high, and then releases both.
- R4: The responder latches the address when it sees the request and raises its acknowledge. It keeps the acknowledge until it sees the request low, and then drops it.
- R5: The master and the responder never drive the data lines in the same cycle.
- R6: The responder raises data-ready no sooner than ACC_DELAY of its own cycles after dropping its acknowledge, and only once it sees the acknowledge line low. Data-ready and the word stay up until it sees the master's acknowledge. It then drops data-ready and releases the lines.
- R7: The master captures the data lines when it sees data-ready and raises its acknowledge. It keeps the acknowledge until it sees data-ready low, and then drops it.
- R8: `rsp_done` is high for exactly one master cycle per transfer. `rsp_data` holds the captured word during that cycle and keeps it until the next transfer captures.
- R9: A command is accepted only when `cmd_valid` and `cmd_ready` are both high at a master clock edge. `cmd_ready` returns high only after the master sees acknowledge and data-ready low again. A `cmd_valid` raised while `cmd_ready` is low is ignored.
- R10: Transfers complete correctly whether the responder clock is slower or faster than the master clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_m | input | 1 | Master-side clock |
| rst_m_n | input | 1 | Master-side asynchronous reset, active low |
| clk_r | input | 1 | Responder-side clock |
| rst_r_n | input | 1 | Responder-side asynchronous reset, active low |
| cmd_valid | input | 1 | Local read command strobe |
| cmd_addr | input | AW | Address of the requested word |
| cmd_ready | output | 1 | Master idle and able to accept a command |
| rsp_data | output | DW | Last captured read word |
| rsp_done | output | 1 | One-cycle pulse marking a completed read |

## Verification
The checks take for granted that both resets start low together and that each side's clock runs from the moment its reset is released. They also assume `cmd_addr` is stable whenever `cmd_valid` is high. The bench drives commands half a master period away from the active edge. It changes the responder clock period only while the link is idle, so no synchronizer ever sees a clock glitch. While a transfer is in flight, it raises `cmd_valid` only in cycles where `cmd_ready` was seen low, so such noise can never become an accepted command.

// File: rtl/hsk_pkg.sv
`timescale 1ns/1ps
package hsk_pkg;

  typedef enum logic [2:0] {
    M_IDLE, M_REQ, M_WRDY, M_ACK, M_DRAIN
  } mst_st_t;

  typedef enum logic [2:0] {
    R_IDLE, R_ACK, R_WAIT, R_RDY, R_END
  } rsp_st_t;

  // Reset content of array cell idx (caller keeps the low bits it needs)
  function automatic logic [31:0] cell_value(input int unsigned idx);
    logic [31:0] p;
    p = idx * 32'h0000_9E37;
    return p ^ 32'h0000_5AC3;
  endfunction

endpackage

// File: rtl/hsk_sync.sv
`timescale 1ns/1ps
module hsk_sync #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1 <= '0;
      q      <= '0;
    end else begin
      stage1 <= d;
      q      <= stage1;
    end
  end
endmodule

// File: rtl/hsk_master.sv
`timescale 1ns/1ps
module hsk_master
  import hsk_pkg::*;
#(
  parameter int DW = 16,
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_valid,
  input  logic [AW-1:0] cmd_addr,
  output logic          cmd_ready,
  input  logic          ack_seen,
  input  logic          rdy_seen,
  input  logic [DW-1:0] bus_in,
  output logic          req,
  output logic          ack,
  output logic          drv,
  output logic [DW-1:0] dout,
  output logic [DW-1:0] rsp_data,
  output logic          rsp_done
);
  mst_st_t       st;
  logic [AW-1:0] addr_q;

  assign cmd_ready = (st == M_IDLE);
  assign drv       = (st == M_REQ);
  assign dout      = DW'(addr_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= M_IDLE;
      addr_q   <= '0;
      req      <= 1'b0;
      ack      <= 1'b0;
      rsp_data <= '0;
      rsp_done <= 1'b0;
    end else begin
      rsp_done <= 1'b0;
      unique case (st)
        M_IDLE: if (cmd_valid) begin
          addr_q <= cmd_addr;
          req    <= 1'b1;
          st     <= M_REQ;
        end
        M_REQ: if (ack_seen) begin
          req <= 1'b0;
          st  <= M_WRDY;
        end
        M_WRDY: if (rdy_seen) begin
          rsp_data <= bus_in;
          ack      <= 1'b1;
          st       <= M_ACK;
        end
        M_ACK: if (!rdy_seen) begin
          ack      <= 1'b0;
          rsp_done <= 1'b1;
          st       <= M_DRAIN;
        end
        M_DRAIN: if (!ack_seen && !rdy_seen) st <= M_IDLE;
        default: st <= M_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/hsk_resp.sv
`timescale 1ns/1ps
module hsk_resp
  import hsk_pkg::*;
#(
  parameter int DW        = 16,
  parameter int DEPTH     = 16,
  parameter int ACC_DELAY = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_seen,
  input  logic          ack_seen,
  input  logic [DW-1:0] bus_in,
  output logic          ack,
  output logic          rdy,
  output logic          drv,
  output logic [DW-1:0] dout
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = (ACC_DELAY > 0) ? $clog2(ACC_DELAY + 1) : 1;

  rsp_st_t       st;
  logic [AW-1:0] addr_q;
  logic [CW-1:0] cnt;
  logic [DW-1:0] mem [DEPTH];
  logic [31:0]   init_v [DEPTH];

  genvar gi;
  generate
    for (gi = 0; gi < DEPTH; gi++) begin : g_init
      assign init_v[gi] = cell_value(gi);
    end
  endgenerate

  assign drv = (st == R_RDY);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= init_v[i][DW-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= R_IDLE;
      addr_q <= '0;
      cnt    <= '0;
      ack    <= 1'b0;
      rdy    <= 1'b0;
      dout   <= '0;
    end else begin
      unique case (st)
        R_IDLE: if (req_seen) begin
          addr_q <= bus_in[AW-1:0];
          ack    <= 1'b1;
          st     <= R_ACK;
        end
        R_ACK: if (!req_seen) begin
          ack <= 1'b0;
          cnt <= CW'(ACC_DELAY);
          st  <= R_WAIT;
        end
        R_WAIT: begin
          if (cnt != '0) cnt <= cnt - 1'b1;
          else if (!ack_seen) begin
            dout <= mem[addr_q];
            rdy  <= 1'b1;
            st   <= R_RDY;
          end
        end
        R_RDY: if (ack_seen) begin
          rdy <= 1'b0;
          st  <= R_END;
        end
        R_END: if (!ack_seen) st <= R_IDLE;
        default: st <= R_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/hsk_read_link.sv
`timescale 1ns/1ps
module hsk_read_link #(
  parameter int DW        = 16,
  parameter int DEPTH     = 16,
  parameter int ACC_DELAY = 3,
  localparam int AW       = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk_m,
  input  logic          rst_m_n,
  input  logic          clk_r,
  input  logic          rst_r_n,
  input  logic          cmd_valid,
  input  logic [AW-1:0] cmd_addr,
  output logic          cmd_ready,
  output logic [DW-1:0] rsp_data,
  output logic          rsp_done
);
  // Shared link lines
  logic          m_req, m_ack, m_drv;
  logic          r_ack, r_rdy, r_drv;
  logic [DW-1:0] m_dout, r_dout, bus_data;
  logic          bus_ack;

  // Synchronized views of the partner's control lines
  logic m_ack_seen, m_rdy_seen;
  logic r_req_seen, r_ack_seen;

  assign bus_ack  = m_ack | r_ack;
  assign bus_data = m_drv ? m_dout : (r_drv ? r_dout : '0);

  hsk_sync #(.W(2)) u_sync_m (
    .clk(clk_m), .rst_n(rst_m_n),
    .d({bus_ack, r_rdy}), .q({m_ack_seen, m_rdy_seen})
  );

  hsk_sync #(.W(2)) u_sync_r (
    .clk(clk_r), .rst_n(rst_r_n),
    .d({m_req, bus_ack}), .q({r_req_seen, r_ack_seen})
  );

  hsk_master #(.DW(DW), .AW(AW)) u_mst (
    .clk(clk_m), .rst_n(rst_m_n),
    .cmd_valid(cmd_valid), .cmd_addr(cmd_addr), .cmd_ready(cmd_ready),
    .ack_seen(m_ack_seen), .rdy_seen(m_rdy_seen), .bus_in(bus_data),
    .req(m_req), .ack(m_ack), .drv(m_drv), .dout(m_dout),
    .rsp_data(rsp_data), .rsp_done(rsp_done)
  );

  hsk_resp #(.DW(DW), .DEPTH(DEPTH), .ACC_DELAY(ACC_DELAY)) u_rsp (
    .clk(clk_r), .rst_n(rst_r_n),
    .req_seen(r_req_seen), .ack_seen(r_ack_seen), .bus_in(bus_data),
    .ack(r_ack), .rdy(r_rdy), .drv(r_drv), .dout(r_dout)
  );
endmodule

// File: rtl/hsk_read_link_chk.sv
`timescale 1ns/1ps
module hsk_read_link_chk #(
  parameter int DW        = 16,
  parameter int ACC_DELAY = 3
) (
  input logic          clk_m,
  input logic          rst_m_n,
  input logic          clk_r,
  input logic          rst_r_n,
  input logic          cmd_ready,
  input logic          rsp_done,
  input logic          m_req,
  input logic          m_ack,
  input logic          m_drv,
  input logic          r_ack,
  input logic          r_rdy,
  input logic          r_drv,
  input logic [DW-1:0] bus_data,
  input logic          m_ack_seen,
  input logic          m_rdy_seen,
  input logic          r_req_seen,
  input logic          r_ack_seen
);
  // Responder cycles since its acknowledge was last high (saturating)
  logic [15:0] since_ack;
  always_ff @(posedge clk_r or negedge rst_r_n) begin
    if (!rst_r_n)              since_ack <= '0;
    else if (r_ack)            since_ack <= '0;
    else if (since_ack != '1)  since_ack <= since_ack + 1'b1;
  end

  a_r5_one_driver_r: assert property (@(posedge clk_r) disable iff (!rst_r_n)
    !(m_drv && r_drv));
  a_r5_one_driver_m: assert property (@(posedge clk_m) disable iff (!rst_m_n)
    !(m_drv && r_drv));
  a_r3_req_held: assert property (@(posedge clk_m) disable iff (!rst_m_n)
    (m_req && !m_ack_seen) |=> m_req);
  a_r4_ack_held: assert property (@(posedge clk_r) disable iff (!rst_r_n)
    (r_ack && r_req_seen) |=> r_ack);
  a_r6_rdy_held: assert property (@(posedge clk_r) disable iff (!rst_r_n)
    (r_rdy && !r_ack_seen) |=> r_rdy);
  a_r6_word_stable: assert property (@(posedge clk_r) disable iff (!rst_r_n)
    (r_drv && $past(r_drv)) |-> $stable(bus_data));
  a_r6_access_delay: assert property (@(posedge clk_r) disable iff (!rst_r_n)
    $rose(r_rdy) |-> (since_ack >= 16'(ACC_DELAY)));
  a_r7_ack_held: assert property (@(posedge clk_m) disable iff (!rst_m_n)
    (m_ack && m_rdy_seen) |=> m_ack);
  a_r8_done_pulse: assert property (@(posedge clk_m) disable iff (!rst_m_n)
    rsp_done |=> !rsp_done);
  a_r9_ready_quiet: assert property (@(posedge clk_m) disable iff (!rst_m_n)
    cmd_ready |-> (!m_ack_seen && !m_rdy_seen && !m_req));
endmodule

bind hsk_read_link hsk_read_link_chk #(.DW(DW), .ACC_DELAY(ACC_DELAY)) u_chk (
  .clk_m(clk_m), .rst_m_n(rst_m_n), .clk_r(clk_r), .rst_r_n(rst_r_n),
  .cmd_ready(cmd_ready), .rsp_done(rsp_done),
  .m_req(m_req), .m_ack(m_ack), .m_drv(m_drv),
  .r_ack(r_ack), .r_rdy(r_rdy), .r_drv(r_drv), .bus_data(bus_data),
  .m_ack_seen(m_ack_seen), .m_rdy_seen(m_rdy_seen),
  .r_req_seen(r_req_seen), .r_ack_seen(r_ack_seen)
);

// File: tb/test_hsk_read_link.sv
`timescale 1ns/1ps
module test_hsk_read_link;
  localparam int DW = 16;
  localparam int DEPTH = 16;
  localparam int AW = 4;
  localparam int ACC_DELAY = 3;

  logic          clk_m = 1'b0, clk_r = 1'b0;
  logic          rst_m_n = 1'b0, rst_r_n = 1'b0;
  logic          cmd_valid = 1'b0;
  logic [AW-1:0] cmd_addr = '0;
  logic          cmd_ready;
  logic [DW-1:0] rsp_data;
  logic          rsp_done;

  int rhalf = 17;
  int n_chk = 0, n_fail = 0;
  int n_issued = 0, n_done = 0;
  bit finished = 1'b0;

  logic [DW-1:0] exp_q[$];
  realtime       t_q[$];
  int            per_q[$];

  always #10 clk_m = ~clk_m;          // 50 MHz master clock
  always #(rhalf) clk_r = ~clk_r;     // responder clock, period varied per phase

  hsk_read_link #(.DW(DW), .DEPTH(DEPTH), .ACC_DELAY(ACC_DELAY)) i_hsk_read_link (
    .clk_m(clk_m), .rst_m_n(rst_m_n), .clk_r(clk_r), .rst_r_n(rst_r_n),
    .cmd_valid(cmd_valid), .cmd_addr(cmd_addr), .cmd_ready(cmd_ready),
    .rsp_data(rsp_data), .rsp_done(rsp_done)
  );

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // R2: expected cell content, restated with shifts and adds
  function automatic logic [DW-1:0] model_word(input int a);
    logic [31:0] prod;
    prod = (a << 15) + (a << 12) + (a << 11) + (a << 10) + (a << 9)
         + (a << 5) + (a << 4) + (a << 2) + (a << 1) + a;   // a * 40503
    return prod[DW-1:0] ^ 16'd23235;
  endfunction

  // Driver: issue one read and push the expectation
  task automatic issue(input int a, input bit noise);
    @(negedge clk_m);
    while (!cmd_ready) @(negedge clk_m);
    cmd_valid = 1'b1;
    cmd_addr  = AW'(a);
    exp_q.push_back(model_word(a));
    t_q.push_back($realtime + 10.0);
    per_q.push_back(2 * rhalf);
    n_issued++;
    @(negedge clk_m);
    cmd_valid = 1'b0;
    if (noise) begin
      // R9: commands offered while busy must be ignored
      for (int k = 0; k < 5; k++) begin
        if (!cmd_ready) begin
          cmd_valid = 1'b1;
          cmd_addr  = ~AW'(a);
        end else cmd_valid = 1'b0;
        @(negedge clk_m);
      end
      cmd_valid = 1'b0;
    end
  endtask

  // Monitor: compare each completed read against the scoreboard
  bit            was_done = 1'b0;
  logic [DW-1:0] last_data = '0;
  always @(negedge clk_m) begin
    if (rst_m_n && !finished) begin
      if (was_done) begin
        check(!rsp_done, "R8 done width", rsp_done, 0);
        check(rsp_data == last_data, "R8 data hold", rsp_data, last_data);
      end
      if (rsp_done) begin
        n_done++;
        if (exp_q.size() == 0) begin
          check(1'b0, "R9 unexpected done", rsp_data, 0);
        end else begin
          logic [DW-1:0] e;
          realtime       t0;
          int            per;
          e   = exp_q.pop_front();
          t0  = t_q.pop_front();
          per = per_q.pop_front();
          check(rsp_data == e, "R2 R3 R4 R5 R7 R10 read word", rsp_data, e);
          check(($realtime - t0) >= real'(ACC_DELAY * per), "R6 access delay",
                longint'($realtime - t0), ACC_DELAY * per);
        end
        last_data = rsp_data;
      end
      was_done = rsp_done;
    end
  end

  task automatic drain();
    int guard = 0;
    while ((exp_q.size() != 0 || !cmd_ready) && guard < 5000) begin
      @(negedge clk_m);
      guard++;
    end
  endtask

  initial begin
    repeat (4) @(negedge clk_m);
    rst_m_n = 1'b1;
    #23 rst_r_n = 1'b1;
    @(negedge clk_m);
    check(cmd_ready == 1'b1, "R1 ready after reset", cmd_ready, 1);
    check(rsp_done == 1'b0, "R1 done after reset", rsp_done, 0);
    check(rsp_data == '0, "R1 data after reset", rsp_data, 0);

    // Slow responder, faster responder, much slower responder (R10)
    for (int ph = 0; ph < 3; ph++) begin
      rhalf = (ph == 0) ? 17 : (ph == 1) ? 4 : 29;
      repeat (3) @(negedge clk_m);
      for (int a = 0; a < DEPTH; a++) issue(a, (a == 5) || (a == 11));
      drain();
    end

    repeat (60) @(negedge clk_m);
    check(n_done == n_issued, "R9 one done per accepted command", n_done, n_issued);
    check(exp_q.size() == 0, "R9 scoreboard empty", exp_q.size(), 0);
    check(cmd_ready == 1'b1, "R9 back to idle", cmd_ready, 1);
    if (!finished) begin
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk_m);
    if (!finished) begin
      finished = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", n_done, 3 * DEPTH);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end
endmodule